// File: doc/BRIEF.md
# Serial Audio Frame Receiver

This block is the receive end of a fixed-format serial audio link. A frame is 256 bits long. It starts with a 16-bit tag word and is followed by twelve 20-bit slots. The sender drives data and the frame marker on the rising edge of the bit clock. The block samples both on the falling edge of that same clock. The block locks onto the first rising edge of the frame marker and counts bits, slots and positions inside each slot. It shifts each slot in most significant bit first.

Once the last bit of a frame has been sampled, the block updates three things together and raises a strobe for one clock:
- the tag word,
- all twelve slot words,
- twelve per-slot valid flags.

A slot is reported valid only when both of these are set:
- the frame-valid bit, which is the top tag bit;
- that slot's own tag bit.

An invalid slot is presented as zero. Two sticky flags report faults on the link:
- a frame marker that is misplaced, missing, or held the wrong length;
- nonzero data inside a slot whose tag bit is clear.

Top module: `slotlink_rx`

## Requirements
- R1: While reset is asserted (synchronous, active low) the strobe, tag word, slot words, valid flags and both error flags are all zero.
- R2: Before the first rising edge of the frame marker after reset, no strobe is produced and neither error flag is set, whatever the data line carries.
- R3: A rising edge of the frame marker marks bit 0 of a frame. The tag word output equals the first 16 bits of the frame, most significant bit first. It is updated together with a strobe that is high for exactly one clock, starting at the falling edge that samples bit 255.
- R4: Slot k (1 to 12) occupies frame bits 16+20(k-1) to 35+20(k-1), most significant bit first. It is presented on slot_data_o bits [20(k-1)+19 : 20(k-1)].
- R5: slot_valid_o bit k-1 equals tag bit 15 AND tag bit 15-k. So tag bit 14 covers slot 1 and tag bit 3 covers slot 12.
- R6: A slot whose valid flag is 0 is presented as all zeros, whatever data it carried.
- R7: A rising edge of the frame marker at any bit count other than 0 (once locked) sets the sticky sync error flag. It also restarts the count, so a complete frame following that edge is decoded correctly.
- R8: Once locked, the frame marker must be high for exactly the 16 tag bits of each frame and low for the rest. A marker held high into the data slots sets the sticky sync error flag.
- R9: A 1 sampled inside a slot whose tag bit (in the current frame) is 0 sets the sticky stuffing error flag. Slots whose tag bit is 1 never set it, even when the frame-valid bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all sampling on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Frame marker, high during the 16 tag bits |
| sdata_i | input | 1 | Serial data, launched on the rising edge |
| frame_done_o | output | 1 | One-clock strobe when a frame's outputs update |
| tag_o | output | 16 | Tag word of the last complete frame |
| slot_data_o | output | 240 | Twelve 20-bit slot words, slot 1 in the low bits |
| slot_valid_o | output | 12 | Per-slot valid flags, bit 0 for slot 1 |
| sync_err_o | output | 1 | Sticky frame-marker fault flag |
| stuff_err_o | output | 1 | Sticky flag for nonzero data in an untagged slot |

## Verification
The bench sends the following tag patterns, each with different slot contents:
- every slot tagged with the frame-valid bit set, which checks bit ordering and slot placement;
- slot tags set with frame-valid clear, which separates the frame-valid gate from the per-slot gate and shows that tagged slots do not trip the stuffing check;
- alternating slot tags with the untagged slots zero-stuffed, which checks per-slot gating on a clean stream.

Fault patterns follow:
- a truncated frame followed by a full one, which separates a counter that restarts on the marker edge from one that free-runs;
- a frame marker held four bits too long;
- nonzero data in an untagged slot.

A long idle stretch after reset shows that nothing is produced before lock.

// File: rtl/slotlink_pkg.sv
// Package: default geometry of the serial audio frame.
// Assumes the tag word carries one frame-valid bit plus one flag per slot.
package slotlink_pkg;
    localparam int TAG_W     = 16;
    localparam int SLOT_W    = 20;
    localparam int NUM_SLOTS = 12;
endpackage

// File: rtl/slotlink_timer.sv
// Module: frame position tracker.
// Detects the rising edge of the frame marker, counts bits, slots and
// positions inside a slot, and flags marker faults (sticky).
// Assumes all inputs are launched on the rising clock edge; samples on falling.
module slotlink_timer #(
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 12,
    localparam int SIX_W    = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    output logic             active,
    output logic             in_tag,
    output logic             tag_last,
    output logic             slot_end,
    output logic             frame_last,
    output logic [SIX_W-1:0] slot_ix,
    output logic             sync_err
);
    localparam int FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int POS_W      = $clog2(SLOT_W);
    localparam logic [CNT_W-1:0] TAG_END_C   = CNT_W'(TAG_W - 1);
    localparam logic [CNT_W-1:0] FRAME_END_C = CNT_W'(FRAME_BITS - 1);
    localparam logic [POS_W-1:0] POS_END_C   = POS_W'(SLOT_W - 1);
    localparam logic [SIX_W-1:0] SIX_END_C   = SIX_W'(NUM_SLOTS - 1);

    logic             sync_q;
    logic             locked;
    logic [CNT_W-1:0] cnt;
    logic [POS_W-1:0] pos;
    logic [SIX_W-1:0] six;
    logic             rise;
    logic [CNT_W-1:0] cur;
    logic             bad;

    // Current bit index: zero on a marker edge, else the running count.
    always_comb begin
        rise       = sync & ~sync_q;
        active     = locked | rise;
        cur        = rise ? '0 : cnt;
        in_tag     = (cur <= TAG_END_C);
        tag_last   = active && (cur == TAG_END_C);
        frame_last = active && (cur == FRAME_END_C);
        slot_end   = (pos == POS_END_C);
        slot_ix    = six;
        bad        = locked && (rise ? (cnt != '0) : (sync != in_tag));
    end

    // Advance the counters; restart them on every marker edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            sync_q   <= 1'b0;
            locked   <= 1'b0;
            cnt      <= '0;
            pos      <= '0;
            six      <= '0;
            sync_err <= 1'b0;
        end else begin
            sync_q <= sync;
            if (rise) locked <= 1'b1;
            if (bad) sync_err <= 1'b1;
            if (rise) begin
                cnt <= CNT_W'(1);
                pos <= '0;
                six <= '0;
            end else if (locked) begin
                cnt <= (cnt == FRAME_END_C) ? '0 : cnt + CNT_W'(1);
                if (!in_tag) begin
                    if (slot_end) begin
                        pos <= '0;
                        six <= (six == SIX_END_C) ? '0 : six + SIX_W'(1);
                    end else begin
                        pos <= pos + POS_W'(1);
                    end
                end
            end
        end
    end

    AST_RESTART_ON_EDGE: assert property (@(negedge clk) disable iff (!rst_n)
        rise |=> (cnt == CNT_W'(1))); // R7
    AST_SYNC_ERR_STICKY: assert property (@(negedge clk) disable iff (!rst_n)
        sync_err |=> sync_err); // R8
    AST_SLOT_IN_RANGE: assert property (@(negedge clk) disable iff (!rst_n)
        (six <= SIX_END_C) && (pos <= POS_END_C)); // R4
endmodule

// File: rtl/slotlink_capture.sv
// Module: serial-to-parallel capture.
// Shifts the tag and slot bits in MSB first, stores finished slot words,
// and checks that untagged slots carry only zeros (sticky flag).
// Assumes position strobes from the timer refer to the bit sampled now.
module slotlink_capture #(
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 12,
    localparam int SIX_W    = $clog2(NUM_SLOTS),
    localparam int FW       = NUM_SLOTS * SLOT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdata,
    input  logic             active,
    input  logic             in_tag,
    input  logic             tag_last,
    input  logic             slot_end,
    input  logic [SIX_W-1:0] slot_ix,
    output logic [TAG_W-1:0] tag_cur,
    output logic [FW-1:0]    words_now,
    output logic             stuff_err
);
    logic [TAG_W-2:0]  tag_sh;
    logic [SLOT_W-2:0] sh;
    logic [SLOT_W-1:0] word_now;
    logic [SLOT_W-1:0] acc [NUM_SLOTS-1];
    logic [NUM_SLOTS-1:0] slot_tag;
    logic              stuff_bad;

    // Word completed by the bit sampled now, and the tag flag of the slot.
    always_comb begin
        word_now  = {sh, sdata};
        stuff_bad = active && !in_tag && sdata && !slot_tag[slot_ix];
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_flag
            assign slot_tag[gi] = tag_cur[TAG_W-2-gi];
            if (gi == NUM_SLOTS - 1) begin : g_last
                assign words_now[gi*SLOT_W +: SLOT_W] = word_now;
            end else begin : g_held
                assign words_now[gi*SLOT_W +: SLOT_W] = acc[gi];
            end
        end
    endgenerate

    // Shift bits in and latch the tag and finished slot words.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            tag_sh    <= '0;
            sh        <= '0;
            tag_cur   <= '0;
            stuff_err <= 1'b0;
            for (int i = 0; i < NUM_SLOTS - 1; i++) acc[i] <= '0;
        end else if (active) begin
            if (stuff_bad) stuff_err <= 1'b1;
            if (in_tag) begin
                tag_sh <= {tag_sh[TAG_W-3:0], sdata};
                if (tag_last) tag_cur <= {tag_sh, sdata};
            end else begin
                sh <= word_now[SLOT_W-2:0];
                if (slot_end) begin
                    for (int i = 0; i < NUM_SLOTS - 1; i++)
                        if (slot_ix == SIX_W'(i)) acc[i] <= word_now;
                end
            end
        end
    end

    AST_STUFF_STICKY: assert property (@(negedge clk) disable iff (!rst_n)
        stuff_err |=> stuff_err); // R9
    AST_TAG_HELD: assert property (@(negedge clk) disable iff (!rst_n)
        !tag_last |=> $stable(tag_cur)); // R3
endmodule

// File: rtl/slotlink_rx.sv
// Module: serial audio frame receiver (top).
// Ties the position tracker to the capture path and registers the frame
// outputs, gating each slot with its tag flag and the frame-valid bit.
// Assumes a single bit clock; everything is sampled on its falling edge.
module slotlink_rx #(
    parameter int TAG_W     = slotlink_pkg::TAG_W,
    parameter int SLOT_W    = slotlink_pkg::SLOT_W,
    parameter int NUM_SLOTS = slotlink_pkg::NUM_SLOTS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sync_i,
    input  logic                        sdata_i,
    output logic                        frame_done_o,
    output logic [TAG_W-1:0]            tag_o,
    output logic [NUM_SLOTS*SLOT_W-1:0] slot_data_o,
    output logic [NUM_SLOTS-1:0]        slot_valid_o,
    output logic                        sync_err_o,
    output logic                        stuff_err_o
);
    localparam int SIX_W = $clog2(NUM_SLOTS);
    localparam int FW    = NUM_SLOTS * SLOT_W;

    logic             active, in_tag, tag_last, slot_end, frame_last;
    logic [SIX_W-1:0] slot_ix;
    logic [TAG_W-1:0] tag_cur;
    logic [FW-1:0]    words_now;
    logic [NUM_SLOTS-1:0] vld_now;
    logic [FW-1:0]    gated_now;

    slotlink_timer #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) timer_i (
        .clk(clk), .rst_n(rst_n), .sync(sync_i), .active(active), .in_tag(in_tag),
        .tag_last(tag_last), .slot_end(slot_end), .frame_last(frame_last),
        .slot_ix(slot_ix), .sync_err(sync_err_o)
    );

    slotlink_capture #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) capture_i (
        .clk(clk), .rst_n(rst_n), .sdata(sdata_i), .active(active), .in_tag(in_tag),
        .tag_last(tag_last), .slot_end(slot_end), .slot_ix(slot_ix),
        .tag_cur(tag_cur), .words_now(words_now), .stuff_err(stuff_err_o)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_gate
            assign vld_now[gi] = tag_cur[TAG_W-1] & tag_cur[TAG_W-2-gi];
            assign gated_now[gi*SLOT_W +: SLOT_W] =
                vld_now[gi] ? words_now[gi*SLOT_W +: SLOT_W] : '0;
            AST_GATED_ZERO: assert property (@(negedge clk) disable iff (!rst_n)
                !slot_valid_o[gi] |-> (slot_data_o[gi*SLOT_W +: SLOT_W] == '0)); // R6
        end
    endgenerate

    // Present the whole frame at once after its last bit.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            frame_done_o <= 1'b0;
            tag_o        <= '0;
            slot_data_o  <= '0;
            slot_valid_o <= '0;
        end else begin
            frame_done_o <= frame_last;
            if (frame_last) begin
                tag_o        <= tag_cur;
                slot_data_o  <= gated_now;
                slot_valid_o <= vld_now;
            end
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(negedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o); // R3
    AST_TAG_WITH_DONE: assert property (@(negedge clk) disable iff (!rst_n)
        !$stable(tag_o) |-> frame_done_o); // R3
    AST_FRAME_VALID_GATE: assert property (@(negedge clk) disable iff (!rst_n)
        !tag_o[TAG_W-1] |-> (slot_valid_o == '0)); // R5
endmodule

// File: tb/slotlink_rx_tb_top.sv
// Scoreboard bench: the frame driver pushes expected frames, the monitor
// pops and compares them on each strobe.
module slotlink_rx_tb_top;
    import slotlink_pkg::*;
    localparam int FW    = NUM_SLOTS * SLOT_W;
    localparam int FBITS = TAG_W + FW;

    logic clk = 1'b0, rst_n = 1'b0, sync = 1'b0, sdata = 1'b0;
    logic frame_done;
    logic [TAG_W-1:0] tag;
    logic [FW-1:0] data;
    logic [NUM_SLOTS-1:0] vld;
    logic sync_err, stuff_err;

    always #5 clk = ~clk;

    slotlink_rx dut_i (
        .clk(clk), .rst_n(rst_n), .sync_i(sync), .sdata_i(sdata),
        .frame_done_o(frame_done), .tag_o(tag), .slot_data_o(data),
        .slot_valid_o(vld), .sync_err_o(sync_err), .stuff_err_o(stuff_err)
    );

    typedef struct packed {
        logic [TAG_W-1:0]     tag;
        logic [FW-1:0]        data;
        logic [NUM_SLOTS-1:0] vld;
    } exp_t;

    exp_t exp_q[$];
    exp_t e_pop;
    int checks = 0, errors = 0, done_seen = 0;
    logic prev_done = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] mk_words(input int seed);
        logic [FW-1:0] w;
        for (int k = 0; k < NUM_SLOTS; k++)
            w[k*SLOT_W +: SLOT_W] = SLOT_W'((k + 1) * 32'h1F3D5 ^ seed * 32'h9E377 ^ 32'h80001);
        return w;
    endfunction

    // Drive nbits of a frame; push the expected result when asked.
    task automatic send_frame(input logic [TAG_W-1:0] t, input logic [FW-1:0] w,
                              input int nbits, input int sync_len, input bit expect_it);
        exp_t e;
        if (expect_it) begin
            e.tag = t;
            for (int k = 0; k < NUM_SLOTS; k++) begin
                e.vld[k] = t[TAG_W-1] & t[TAG_W-2-k];
                e.data[k*SLOT_W +: SLOT_W] = e.vld[k] ? w[k*SLOT_W +: SLOT_W] : '0;
            end
            exp_q.push_back(e);
        end
        for (int b = 0; b < nbits && b < FBITS; b++) begin
            logic bv;
            if (b < TAG_W) bv = t[TAG_W-1-b];
            else begin
                int s;
                int p;
                s  = (b - TAG_W) / SLOT_W;
                p  = (b - TAG_W) % SLOT_W;
                bv = w[s*SLOT_W + SLOT_W - 1 - p];
            end
            @(posedge clk);
            sync  <= (b < sync_len);
            sdata <= bv;
        end
    endtask

    task automatic do_reset();
        @(posedge clk);
        rst_n <= 1'b0;
        sync  <= 1'b0;
        sdata <= 1'b0;
        repeat (3) @(posedge clk);
        rst_n <= 1'b1;
    endtask

    // Checks right after the last bit of a frame has been sampled.
    task automatic after_frame();
        @(posedge clk);
        #1;
    endtask

    // Monitor: compare every strobe against the scoreboard.
    always @(posedge clk) begin
        if (rst_n && frame_done) begin
            done_seen++;
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2 unexpected frame_done actual=1 expected=0");
            end else begin
                e_pop = exp_q.pop_front();
                chk("R3", "tag", FW'(tag), FW'(e_pop.tag));
                chk("R4", "slot data", data, e_pop.data);
                chk("R5", "slot valid", FW'(vld), FW'(e_pop.vld));
            end
            if (prev_done) begin
                checks++;
                errors++;
                $display("FAIL R3 strobe longer than one cycle actual=2 expected=1");
            end
        end
        prev_done <= frame_done;
    end

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [FW-1:0] w3;
        logic [TAG_W-1:0] t3;
        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        chk("R1", "frame_done", FW'(frame_done), '0);
        chk("R1", "tag", FW'(tag), '0);
        chk("R1", "data", data, '0);
        chk("R1", "valid", FW'(vld), '0);
        chk("R1", "errors", FW'({sync_err, stuff_err}), '0);
        do_reset();

        // R2: no marker, busy data line
        for (int i = 0; i < 300; i++) begin
            @(posedge clk);
            sdata <= 1'b1;
        end
        after_frame();
        chk("R2", "strobes before lock", FW'(done_seen), '0);
        chk("R2", "error flags before lock", FW'({sync_err, stuff_err}), '0);
        do_reset();

        // R3 R4 R5 R6: three clean back-to-back frames
        send_frame(16'hFFF8, mk_words(1), FBITS, TAG_W, 1'b1);
        send_frame(16'h7FF8, mk_words(2), FBITS, TAG_W, 1'b1);
        t3 = 16'hAAA8;
        w3 = mk_words(3);
        for (int k = 0; k < NUM_SLOTS; k++)
            if (!t3[TAG_W-2-k]) w3[k*SLOT_W +: SLOT_W] = '0;
        send_frame(t3, w3, FBITS, TAG_W, 1'b1);
        after_frame();
        chk("R9", "stuff_err on clean stream", FW'(stuff_err), '0);
        chk("R8", "sync_err on clean stream", FW'(sync_err), '0);
        chk("R3", "frames consumed", FW'(exp_q.size()), '0);
        chk("R3", "strobe count", FW'(done_seen), FW'(3));
        do_reset();

        // R7: truncated frame, then a full one after an early marker edge
        send_frame(16'hFFF8, mk_words(4), FBITS, TAG_W, 1'b1);
        send_frame(16'hFFF8, mk_words(5), 100, TAG_W, 1'b0);
        send_frame(16'hF0F8, mk_words(6), FBITS, TAG_W, 1'b1);
        after_frame();
        chk("R7", "sync_err after early edge", FW'(sync_err), FW'(1));
        chk("R7", "frames consumed after restart", FW'(exp_q.size()), '0);
        do_reset();

        // R8: marker held four bits too long
        send_frame(16'hFFF8, mk_words(7), FBITS, TAG_W, 1'b1);
        send_frame(16'hFFF8, mk_words(8), FBITS, TAG_W + 4, 1'b1);
        after_frame();
        chk("R8", "sync_err after long marker", FW'(sync_err), FW'(1));
        chk("R8", "frames consumed", FW'(exp_q.size()), '0);
        do_reset();

        // R9 R6: slot 3 untagged but carrying nonzero data
        send_frame(16'hEFF8, mk_words(9), FBITS, TAG_W, 1'b1);
        after_frame();
        chk("R9", "stuff_err after dirty slot", FW'(stuff_err), FW'(1));
        chk("R9", "sync_err stays clear", FW'(sync_err), '0);
        chk("R6", "slot 3 gated to zero", FW'(data[2*SLOT_W +: SLOT_W]), '0);
        chk("R6", "frames consumed", FW'(exp_q.size()), '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule